// File: doc/BRIEF.md
# Indirect Auto-Increment Register Port

This block is the host-facing register access unit of a bus-interface controller. The host sees just two byte locations, picked by `hostSel`. On the address side, a write loads an internal register pointer and a read returns an auxiliary status byte. On the value side, each access reads or writes the register the pointer names and then moves the pointer on by one. Multi-byte fields such as the 24-bit transfer count can therefore be written or read as one burst after a single address write.

The block holds the register file and gates host access by the protocol engine's state. While the engine is busy, only the command and data registers remain open. While a command is in progress, the command register is closed as well. A command written during that time is discarded and recorded in a sticky flag. The engine is outside this block and appears only as status inputs and an interrupt request. The request loads a cause byte and raises an interrupt-pending flag. The host clears that flag by reading the cause register.

Top module: `ind_regport`

## Requirements
- R1: A write to the address side (`hostSel`=0) loads the pointer from the low 5 bits of `hostWdata`. A read on the address side leaves the pointer unchanged.
- R2: A read on the address side returns the status byte with these bits: bit 7 interrupt pending, bit 6 command ignored, bit 5 `engBusy`, bit 4 `engCip`, bit 1 `engParErr`, bit 0 `engDbr`. Bits 3 and 2 are zero.
- R3: Every value-side access (`hostSel`=1) adds one to the pointer, and this happens whether or not the access is blocked. The pointer goes from 31 to 0. If `hostWr` and `hostRd` are both high, the access is treated as a write.
- R4: Registers 0 to 25 store the bytes written to them and return them on reads. Register numbers 26 to 31 read as 0x00 and ignore writes.
- R5: `xferCount` shows registers 18, 19 and 20 as one 24-bit value, with register 18 as the most significant byte.
- R6: While `engBusy` is high, only registers 24 (command) and 25 (data) can be accessed. Reads of other registers return 0x00, and writes to them change nothing.
- R7: While `engCip` is high, register 24 is also blocked. A write to it is discarded, sets the command-ignored flag, and produces no `cmdValid` pulse.
- R8: An accepted write to register 24 raises `cmdValid` for exactly one cycle after the write edge, with `cmdByte` equal to the written byte. In that byte, bit 7 is the single-byte-transfer qualifier and bits 6:0 are the command code.
- R9: An `engIrq` pulse loads `engCause` into register 23 and sets interrupt pending on the next edge. In the same cycle, the engine load takes priority over a host write to register 23. The upper nibble of the cause byte is the class: 0x0 reset, 0x1 completed, 0x2 paused, 0x4 terminated, 0x8 service needed.
- R10: An unblocked read of register 23 clears both interrupt pending and command ignored. A read blocked by `engBusy` clears neither. If `engIrq` arrives in the same cycle as the read, interrupt pending stays set.
- R11: Synchronous reset `rst` clears the pointer, all registers, both flags and `cmdValid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| hostSel | input | 1 | 0 = address/status side, 1 = value side |
| hostWr | input | 1 | Host write strobe, one cycle per access |
| hostRd | input | 1 | Host read strobe, one cycle per access |
| hostWdata | input | 8 | Host write data |
| hostRdata | output | 8 | Read data, valid in the cycle `hostRd` is high |
| engBusy | input | 1 | Engine busy |
| engCip | input | 1 | Engine command in progress |
| engIrq | input | 1 | Engine interrupt request pulse |
| engCause | input | 8 | Cause byte loaded on `engIrq` |
| engParErr | input | 1 | Parity error status |
| engDbr | input | 1 | Data buffer ready status |
| xferCount | output | 24 | Transfer count, taken from registers 18..20 |
| cmdByte | output | 8 | Contents of the command register |
| cmdValid | output | 1 | One-cycle pulse after an accepted command write |

## Verification
The bench builds the block with its default parameters: an 8-bit data path, a 5-bit pointer, 26 registers, command at 24, data at 25, cause at 23, and a 3-byte count at 18. With these values a 5-bit pointer addresses 32 locations but only 26 are registers. The unmapped numbers 26 to 31 and the wrap from 31 to 0 can therefore be reached in a few accesses. A three-write burst is enough to fill the whole count field. The bench drives `engIrq` in the same cycle as a cause read and as a cause write, which covers both priority cases of R9 and R10.

// File: rtl/regport_pkg.sv
package regport_pkg;

  // Strobes sent from the control module to the datapath, one set per cycle.
  typedef struct packed {
    logic ptrLoad;   // address-side write: load the pointer
    logic ptrStep;   // value-side access: advance the pointer
    logic regWe;     // value-side write that is allowed
    logic cmdFire;   // accepted write to the command register
    logic causeRd;   // unblocked read of the cause register
  } portStrobe_t;

endpackage

// File: rtl/regport_ctrl.sv
module regport_ctrl
  import regport_pkg::*;
#(
  parameter int PTR_W     = 5,
  parameter int NUM_REGS  = 26,
  parameter int CMD_IDX   = 24,
  parameter int DATA_IDX  = 25,
  parameter int CAUSE_IDX = 23
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hostSel,
  input  logic             hostWr,
  input  logic             hostRd,
  input  logic [PTR_W-1:0] ptr,
  input  logic             engBusy,
  input  logic             engCip,
  input  logic             engIrq,
  output portStrobe_t      strobe,
  output logic             visible,
  output logic             irqPend,
  output logic             cmdIgnored
);

  localparam logic [PTR_W:0]   REG_LIMIT = (PTR_W+1)'(NUM_REGS);
  localparam logic [PTR_W-1:0] CMD_P     = PTR_W'(CMD_IDX);
  localparam logic [PTR_W-1:0] DATA_P    = PTR_W'(DATA_IDX);
  localparam logic [PTR_W-1:0] CAUSE_P   = PTR_W'(CAUSE_IDX);

  logic inRange, isCmd, isData, isCause;
  logic busyBlock, cipBlock;
  logic valAccess, cmdDrop;

  always_comb begin
    inRange   = ({1'b0, ptr} < REG_LIMIT);
    isCmd     = (ptr == CMD_P);
    isData    = (ptr == DATA_P);
    isCause   = (ptr == CAUSE_P);
    busyBlock = engBusy && !isCmd && !isData;
    cipBlock  = engCip && isCmd;
    visible   = inRange && !busyBlock && !cipBlock;
    valAccess = hostSel && (hostWr || hostRd);
    cmdDrop   = valAccess && hostWr && engCip && isCmd;
  end

  always_comb begin
    strobe.ptrLoad = !hostSel && hostWr;
    strobe.ptrStep = valAccess;
    strobe.regWe   = valAccess && hostWr && visible;
    strobe.cmdFire = valAccess && hostWr && visible && isCmd;
    strobe.causeRd = valAccess && !hostWr && visible && isCause;
  end

  // Flags: an engine request takes priority over clearing by a cause read.
  always_ff @(posedge clk) begin
    if (rst) begin
      irqPend    <= 1'b0;
      cmdIgnored <= 1'b0;
    end else begin
      if (engIrq)              irqPend <= 1'b1;
      else if (strobe.causeRd) irqPend <= 1'b0;

      if (cmdDrop)             cmdIgnored <= 1'b1;
      else if (strobe.causeRd) cmdIgnored <= 1'b0;
    end
  end

endmodule

// File: rtl/regport_data.sv
module regport_data
  import regport_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int PTR_W     = 5,
  parameter int NUM_REGS  = 26,
  parameter int CMD_IDX   = 24,
  parameter int CAUSE_IDX = 23,
  parameter int CNT_IDX   = 18,
  parameter int CNT_BYTES = 3
) (
  input  logic                        clk,
  input  logic                        rst,
  input  portStrobe_t                 strobe,
  input  logic                        visible,
  input  logic                        hostSel,
  input  logic [DATA_W-1:0]           hostWdata,
  input  logic [DATA_W-1:0]           statusByte,
  input  logic                        engIrq,
  input  logic [DATA_W-1:0]           engCause,
  output logic [PTR_W-1:0]            ptr,
  output logic [DATA_W-1:0]           hostRdata,
  output logic [CNT_BYTES*DATA_W-1:0] xferCount,
  output logic [DATA_W-1:0]           cmdByte,
  output logic                        cmdValid
);

  logic [DATA_W-1:0] regs [NUM_REGS];
  logic [DATA_W-1:0] regVal;

  // Pointer: load from the address side, or step on any value-side access (wraps).
  always_ff @(posedge clk) begin
    if (rst)                 ptr <= '0;
    else if (strobe.ptrLoad) ptr <= hostWdata[PTR_W-1:0];
    else if (strobe.ptrStep) ptr <= ptr + 1'b1;
  end

  // Register file; the cause entry also has an engine load path.
  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    localparam logic [PTR_W-1:0] IDX = PTR_W'(i);
    if (i == CAUSE_IDX) begin : g_cause
      always_ff @(posedge clk) begin
        if (rst)                               regs[i] <= '0;
        else if (engIrq)                       regs[i] <= engCause;
        else if (strobe.regWe && (ptr == IDX)) regs[i] <= hostWdata;
      end
    end else begin : g_plain
      always_ff @(posedge clk) begin
        if (rst)                               regs[i] <= '0;
        else if (strobe.regWe && (ptr == IDX)) regs[i] <= hostWdata;
      end
    end
  end

  always_comb begin
    regVal = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (ptr == PTR_W'(i)) regVal = regs[i];
    end
  end

  always_comb begin
    if (!hostSel)     hostRdata = statusByte;
    else if (visible) hostRdata = regVal;
    else              hostRdata = '0;
  end

  // Count field: the lowest-numbered register is the most significant byte.
  for (genvar b = 0; b < CNT_BYTES; b++) begin : g_cnt
    assign xferCount[(CNT_BYTES-1-b)*DATA_W +: DATA_W] = regs[CNT_IDX+b];
  end

  assign cmdByte = regs[CMD_IDX];

  always_ff @(posedge clk) begin
    if (rst) cmdValid <= 1'b0;
    else     cmdValid <= strobe.cmdFire;
  end

endmodule

// File: rtl/ind_regport.sv
module ind_regport
  import regport_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int PTR_W     = 5,
  parameter int NUM_REGS  = 26,
  parameter int CMD_IDX   = 24,
  parameter int DATA_IDX  = 25,
  parameter int CAUSE_IDX = 23,
  parameter int CNT_IDX   = 18,
  parameter int CNT_BYTES = 3
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        hostSel,
  input  logic                        hostWr,
  input  logic                        hostRd,
  input  logic [DATA_W-1:0]           hostWdata,
  output logic [DATA_W-1:0]           hostRdata,
  input  logic                        engBusy,
  input  logic                        engCip,
  input  logic                        engIrq,
  input  logic [DATA_W-1:0]           engCause,
  input  logic                        engParErr,
  input  logic                        engDbr,
  output logic [CNT_BYTES*DATA_W-1:0] xferCount,
  output logic [DATA_W-1:0]           cmdByte,
  output logic                        cmdValid
);

  portStrobe_t       strobe;
  logic              visible;
  logic              irqPend;
  logic              cmdIgnored;
  logic [PTR_W-1:0]  ptr;
  logic [DATA_W-1:0] statusByte;

  assign statusByte = DATA_W'({irqPend, cmdIgnored, engBusy, engCip,
                               2'b00, engParErr, engDbr});

  regport_ctrl #(
    .PTR_W(PTR_W), .NUM_REGS(NUM_REGS), .CMD_IDX(CMD_IDX),
    .DATA_IDX(DATA_IDX), .CAUSE_IDX(CAUSE_IDX)
  ) u_ctrl (
    .clk(clk), .rst(rst), .hostSel(hostSel), .hostWr(hostWr), .hostRd(hostRd),
    .ptr(ptr), .engBusy(engBusy), .engCip(engCip), .engIrq(engIrq),
    .strobe(strobe), .visible(visible), .irqPend(irqPend), .cmdIgnored(cmdIgnored)
  );

  regport_data #(
    .DATA_W(DATA_W), .PTR_W(PTR_W), .NUM_REGS(NUM_REGS), .CMD_IDX(CMD_IDX),
    .CAUSE_IDX(CAUSE_IDX), .CNT_IDX(CNT_IDX), .CNT_BYTES(CNT_BYTES)
  ) u_data (
    .clk(clk), .rst(rst), .strobe(strobe), .visible(visible), .hostSel(hostSel),
    .hostWdata(hostWdata), .statusByte(statusByte), .engIrq(engIrq),
    .engCause(engCause), .ptr(ptr), .hostRdata(hostRdata),
    .xferCount(xferCount), .cmdByte(cmdByte), .cmdValid(cmdValid)
  );

endmodule

// File: rtl/regport_chk.sv
module regport_chk #(
  parameter int DATA_W    = 8,
  parameter int PTR_W     = 5,
  parameter int NUM_REGS  = 26,
  parameter int CMD_IDX   = 24,
  parameter int DATA_IDX  = 25,
  parameter int CAUSE_IDX = 23
) (
  input logic              clk,
  input logic              rst,
  input logic              hostSel,
  input logic              hostWr,
  input logic              hostRd,
  input logic [DATA_W-1:0] hostWdata,
  input logic [DATA_W-1:0] hostRdata,
  input logic              engBusy,
  input logic              engCip,
  input logic              engIrq,
  input logic              cmdValid,
  input logic [DATA_W-1:0] cmdByte,
  input logic [PTR_W-1:0]  ptr,
  input logic              irqPend,
  input logic              cmdIgnored
);

  localparam logic [PTR_W-1:0] CMD_P   = PTR_W'(CMD_IDX);
  localparam logic [PTR_W-1:0] DATA_P  = PTR_W'(DATA_IDX);
  localparam logic [PTR_W-1:0] CAUSE_P = PTR_W'(CAUSE_IDX);
  localparam logic [PTR_W:0]   LIMIT   = (PTR_W+1)'(NUM_REGS);

  a_r1_ptr_load: assert property (@(posedge clk) disable iff (rst)
    (!hostSel && hostWr) |=> (ptr == $past(hostWdata[PTR_W-1:0])));

  a_r3_ptr_step: assert property (@(posedge clk) disable iff (rst)
    (hostSel && (hostWr || hostRd)) |=> (ptr == PTR_W'($past(ptr) + 1'b1)));

  a_r4_unmapped_zero: assert property (@(posedge clk) disable iff (rst)
    (hostSel && hostRd && !hostWr && ({1'b0, ptr} >= LIMIT)) |-> (hostRdata == '0));

  a_r6_busy_read_zero: assert property (@(posedge clk) disable iff (rst)
    (hostSel && hostRd && !hostWr && engBusy && ptr != CMD_P && ptr != DATA_P)
      |-> (hostRdata == '0));

  a_r7_cmd_drop: assert property (@(posedge clk) disable iff (rst)
    (hostSel && hostWr && engCip && ptr == CMD_P) |=> (cmdIgnored && !cmdValid));

  a_r8_cmd_pulse: assert property (@(posedge clk) disable iff (rst)
    (hostSel && hostWr && !engCip && ptr == CMD_P)
      |=> (cmdValid && cmdByte == $past(hostWdata)));

  a_r9_irq_set: assert property (@(posedge clk) disable iff (rst)
    engIrq |=> irqPend);

  a_r10_cause_clear: assert property (@(posedge clk) disable iff (rst)
    (hostSel && hostRd && !hostWr && !engBusy && !engIrq && ptr == CAUSE_P)
      |=> (!irqPend && !cmdIgnored));

endmodule

bind ind_regport regport_chk u_chk (
  .clk(clk), .rst(rst), .hostSel(hostSel), .hostWr(hostWr), .hostRd(hostRd),
  .hostWdata(hostWdata), .hostRdata(hostRdata), .engBusy(engBusy),
  .engCip(engCip), .engIrq(engIrq), .cmdValid(cmdValid), .cmdByte(cmdByte),
  .ptr(ptr), .irqPend(irqPend), .cmdIgnored(cmdIgnored)
);

// File: tb/test_ind_regport.sv
module test_ind_regport;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        hostSel = 1'b0, hostWr = 1'b0, hostRd = 1'b0;
  logic [7:0]  hostWdata = '0;
  logic [7:0]  hostRdata;
  logic        engBusy = 1'b0, engCip = 1'b0, engIrq = 1'b0;
  logic [7:0]  engCause = '0;
  logic        engParErr = 1'b0, engDbr = 1'b0;
  logic [23:0] xferCount;
  logic [7:0]  cmdByte;
  logic        cmdValid;

  int checks = 0;
  int errors = 0;
  logic [7:0] expQ[$];
  string      tagQ[$];

  always #2.5 clk = ~clk;

  ind_regport i_ind_regport (
    .clk(clk), .rst(rst), .hostSel(hostSel), .hostWr(hostWr), .hostRd(hostRd),
    .hostWdata(hostWdata), .hostRdata(hostRdata), .engBusy(engBusy),
    .engCip(engCip), .engIrq(engIrq), .engCause(engCause),
    .engParErr(engParErr), .engDbr(engDbr), .xferCount(xferCount),
    .cmdByte(cmdByte), .cmdValid(cmdValid)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // Driver: one host access per call; reads push their expected byte.
  task automatic access(input bit sel, input bit wr, input logic [7:0] d,
                        input logic [7:0] exp, input string tag,
                        input bit irq = 1'b0, input logic [7:0] cz = 8'h00);
    @(negedge clk);
    hostSel = sel; hostWr = wr; hostRd = !wr; hostWdata = d;
    engIrq = irq; engCause = cz;
    if (!wr) begin
      expQ.push_back(exp);
      tagQ.push_back(tag);
    end
    @(negedge clk);
    hostWr = 1'b0; hostRd = 1'b0; engIrq = 1'b0;
  endtask

  task automatic setPtr(input logic [7:0] a);
    access(1'b0, 1'b1, a, 8'h00, "");
  endtask
  task automatic wrVal(input logic [7:0] d);
    access(1'b1, 1'b1, d, 8'h00, "");
  endtask
  task automatic rdVal(input logic [7:0] exp, input string tag);
    access(1'b1, 1'b0, 8'h00, exp, tag);
  endtask
  task automatic rdStat(input logic [7:0] exp, input string tag);
    access(1'b0, 1'b0, 8'h00, exp, tag);
  endtask

  // Monitor: compares each read result against the queue head.
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (hostRd) begin
        if (expQ.size() == 0) begin
          checks++; errors++;
          $display("FAIL scoreboard: actual 0x%0h expected no read", hostRdata);
        end else begin
          logic [7:0] e;
          string t;
          e = expQ.pop_front();
          t = tagQ.pop_front();
          chk({24'h0, hostRdata}, {24'h0, e}, t);
        end
      end
    end
  end

  initial begin
    #(5 * 20000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R11 reset state
    rdStat(8'h00, "R11 status after reset");
    chk(xferCount, 0, "R11 count after reset");
    chk(cmdValid, 0, "R11 cmdValid after reset");
    rdVal(8'h00, "R11 reg0 after reset");

    // R3/R4 burst write then burst read
    setPtr(8'd3);
    wrVal(8'h11); wrVal(8'h22); wrVal(8'h33);
    setPtr(8'd3);
    rdVal(8'h11, "R4 reg3"); rdVal(8'h22, "R3 stream reg4"); rdVal(8'h33, "R3 stream reg5");

    // R5 count field, MSB first
    setPtr(8'd18);
    wrVal(8'hAB); wrVal(8'hCD); wrVal(8'hEF);
    chk(xferCount, 32'h00ABCDEF, "R5 count value");

    // R4 unmapped numbers
    setPtr(8'd26);
    wrVal(8'h55);
    setPtr(8'd26);
    rdVal(8'h00, "R4 unmapped reads zero");

    // R3 wrap 31 -> 0
    setPtr(8'd30);
    wrVal(8'h01); wrVal(8'h02); wrVal(8'h77);
    setPtr(8'd0);
    rdVal(8'h77, "R3 wrap lands in reg0");
    rdVal(8'h00, "R4 reg1 untouched");

    // R1 low bits only, status read keeps pointer
    setPtr(8'h23);
    rdVal(8'h11, "R1 upper address bits ignored");
    setPtr(8'd4);
    rdStat(8'h00, "R2 idle status");
    rdVal(8'h22, "R1 status read keeps pointer");

    // R2 status layout
    engBusy = 1'b1; engCip = 1'b1; engParErr = 1'b1; engDbr = 1'b1;
    rdStat(8'h33, "R2 status bits");
    engBusy = 1'b0; engCip = 1'b0; engParErr = 1'b0; engDbr = 1'b0;

    // R6 busy gating
    engBusy = 1'b1;
    setPtr(8'd3);
    rdVal(8'h00, "R6 blocked read");
    wrVal(8'h99);
    setPtr(8'd25);
    wrVal(8'h5A);
    setPtr(8'd25);
    rdVal(8'h5A, "R6 data reg open while busy");
    setPtr(8'd24);
    wrVal(8'h05);
    chk(cmdValid, 1, "R6 cmd accepted while busy");
    chk(cmdByte, 8'h05, "R6 cmd byte while busy");
    engBusy = 1'b0;
    setPtr(8'd3);
    rdVal(8'h11, "R6 reg3 intact");
    rdVal(8'h22, "R6 blocked write dropped");
    chk(cmdValid, 0, "R8 pulse ended");

    // R7 command in progress
    engCip = 1'b1;
    setPtr(8'd24);
    wrVal(8'h81);
    chk(cmdValid, 0, "R7 no pulse on dropped cmd");
    rdStat(8'h50, "R7 ignored flag set");
    setPtr(8'd24);
    rdVal(8'h00, "R7 cmd hidden");
    engCip = 1'b0;
    setPtr(8'd24);
    rdVal(8'h05, "R7 old cmd kept");

    // R8 accepted command
    setPtr(8'd24);
    wrVal(8'h8C);
    chk(cmdValid, 1, "R8 pulse");
    chk(cmdByte[7], 1, "R8 single-byte qualifier");
    chk(cmdByte[6:0], 7'h0C, "R8 command code");
    @(negedge clk);
    chk(cmdValid, 0, "R8 one cycle only");

    // R9 engine interrupt
    @(negedge clk);
    engIrq = 1'b1; engCause = 8'h42;
    @(negedge clk);
    engIrq = 1'b0;
    rdStat(8'hC0, "R9 pending set");

    // R10 clearing rules
    engBusy = 1'b1;
    setPtr(8'd23);
    rdVal(8'h00, "R10 blocked cause read");
    rdStat(8'hE0, "R10 flags kept when blocked");
    engBusy = 1'b0;
    setPtr(8'd23);
    rdVal(8'h42, "R9 cause loaded");
    rdStat(8'h00, "R10 flags cleared");
    setPtr(8'd23);
    access(1'b1, 1'b0, 8'h00, 8'h42, "R10 read with new request", 1'b1, 8'h17);
    rdStat(8'h80, "R10 new request wins");
    setPtr(8'd23);
    rdVal(8'h17, "R9 cause reloaded");
    rdStat(8'h00, "R10 cleared again");
    setPtr(8'd23);
    access(1'b1, 1'b1, 8'h99, 8'h00, "", 1'b1, 8'h84);
    setPtr(8'd23);
    rdVal(8'h84, "R9 engine beats host write");

    // R11 reset from a loaded state
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk); rst = 1'b0;
    rdStat(8'h00, "R11 status after second reset");
    chk(xferCount, 0, "R11 count cleared");
    rdVal(8'h00, "R11 pointer and reg0 cleared");

    while (expQ.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule